// File: doc/BRIEF.md
# Multi-mode double-buffered PWM peripheral

This block produces two pulse-width-modulated outputs from one 16-bit counter. Software drives it over a byte-wide write bus that reaches three registers: an 8-bit control register and two 16-bit duty registers. The control register picks an operating mode, one of four tick sources and one of four prescale ratios. Each duty register is written as two bytes. The low byte is parked in a hidden holding byte, and the high-byte write then commits both bytes at once into a pending value. The counter picks up that pending value only when its current period ends, so an output never runs a period built from half-old and half-new data.

Two modes drive outputs. In the single variable-resolution mode, duty register 1 sets the period and duty register 0 sets the high time of output 0. In the twin 16-bit mode, the counter spans the whole 16-bit range and each output compares against its own duty register. Every other mode code holds the counter at zero and drives both outputs low. All tick sources are enable strobes in the system clock domain. The only exception is the external clock pin, which passes through a two-flop synchroniser and a rising-edge detector.

Top module: `pwm_core`

## Requirements
- R1: While rst_ni is low and just after it rises, both outputs are low and the control register reads as mode 0 (disabled).
- R2: Register addresses are 0 control, 1 duty-0 low byte, 2 duty-0 high byte, 3 duty-1 low byte and 4 duty-1 high byte. Control bits 6:4 hold the mode, bits 3:2 the prescale code and bits 1:0 the tick source, and bit 7 is ignored.
- R3: Mode 1 (single variable-resolution): the counter runs 0..P, where P is duty register 1, and then wraps to 0. Output 0 is high while the counter is below duty register 0. Output 1 is always low.
- R4: Mode 3 (twin 16-bit): the counter runs 0..65535 and wraps. Output k is high while the counter is below duty register k, so a value of 0 gives a constant low and 65535 is low only at count 65535.
- R5: In modes 0, 2, 4, 5, 6 and 7 the counter is held at zero and both outputs are low.
- R6: Prescale code 0, 1, 2 or 3 advances the counter once every 1, 4, 16 or 64 source ticks.
- R7: Tick source code 00 is every system clock, 01 is slow_tick_i, 11 is alt_tick_i and 10 is the external pin. Strobes on a source that is not selected have no effect.
- R8: On source 10, each rising edge of ext_clk_i advances the prescaler exactly once after a two-flop synchroniser, and a pin held high counts only once.
- R9: A low-byte write alone does not change the value a duty register presents to the outputs.
- R10: A high-byte write commits {high, held low} as the pending value. While a period is running, that value takes effect only from the start of the next period. While the block is disabled, it takes effect one cycle after the write.
- R11: Any control write restarts the counter and prescaler at zero and loads the pending duty values at once.
- R12: If a high-byte write lands in the same cycle as the last tick of a period, the period that follows still uses the previous value and the new value takes effect one period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| slow_tick_i | input | 1 | Internal tick strobe, source 01 |
| alt_tick_i | input | 1 | Internal tick strobe, source 11 |
| ext_clk_i | input | 1 | Asynchronous external clock, source 10 |
| pwm_o | output | 2 | PWM outputs, bit 0 is output 0 |

## Verification
The period-end reload and a high-byte commit can land in the same clock edge. The bench provokes this in mode 1 with period 9: it counts to 8 and then times the two byte writes so that the high byte is captured exactly on the wrapping tick. It then judges the result by counting high cycles of output 0 over the next two periods. It expects the old duty in the first period and the new duty in the second. A related case is a control rewrite in the middle of a period. It is judged by requiring output 0 to be high on the very next sample, which shows the counter restarted at zero.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DIV_W  = 2;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_VARRES = 3'd1,
    MODE_TWIN8  = 3'd2,
    MODE_TWIN16 = 3'd3,
    MODE_NRZ16  = 3'd4,
    MODE_DUAL8  = 3'd5,
    MODE_RZ16   = 3'd6,
    MODE_RSVD   = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    SRC_SYS  = 2'd0,
    SRC_SLOW = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_ALT  = 2'd3
  } src_e;

  typedef struct packed {
    mode_e             mode;
    logic [DIV_W-1:0]  div;
    src_e              src;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = '0;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned AW  = ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic              restart_o,
  output logic [DW-1:0]     pend_o [NCH]
);
  localparam int unsigned HI_W = DW - BYTE_W;

  logic  ctrl_sel;
  ctrl_t ctrl_q;

  assign ctrl_sel = we_i && (addr_i == ADDR_CTRL);

  // reserved top bit is not stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (ctrl_sel) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  assign ctrl_o    = ctrl_q;
  assign restart_o = ctrl_sel;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic              lo_sel, hi_sel;
    logic [BYTE_W-1:0] hold_q;
    logic [DW-1:0]     data_q;

    assign lo_sel = we_i && (addr_i == AW'(2 * ch + 1));
    assign hi_sel = we_i && (addr_i == AW'(2 * ch + 2));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q <= '0;
        data_q <= '0;
      end else begin
        if (lo_sel) hold_q <= wdata_i;
        if (hi_sel) data_q <= {wdata_i[HI_W-1:0], hold_q};
      end
    end

    assign pend_o[ch] = data_q;
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_pkg::*;
#(
  parameter int unsigned DW_DIV      = DIV_W,
  parameter int unsigned DIV_STEP    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  src_e              src_i,
  input  logic [DW_DIV-1:0] div_i,
  input  logic              restart_i,
  input  logic              slow_tick_i,
  input  logic              alt_tick_i,
  input  logic              ext_clk_i,
  output logic              tick_o
);
  localparam int unsigned PRE_W = DIV_STEP * ((2 ** DW_DIV) - 1);

  logic [SYNC_STAGES:0] ext_sh_q;
  logic                 ext_rise;
  logic                 src_tick;
  logic [PRE_W-1:0]     pre_q;
  logic [PRE_W-1:0]     lim;
  logic                 pre_hit;

  // last stage is the edge-detect delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_sh_q <= '0;
    else         ext_sh_q <= {ext_sh_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign ext_rise = ext_sh_q[SYNC_STAGES-1] && !ext_sh_q[SYNC_STAGES];

  always_comb begin
    unique case (src_i)
      SRC_SYS:  src_tick = 1'b1;
      SRC_SLOW: src_tick = slow_tick_i;
      SRC_EXT:  src_tick = ext_rise;
      SRC_ALT:  src_tick = alt_tick_i;
      default:  src_tick = 1'b0;
    endcase
  end

  // divide ratio 2**(DIV_STEP*div) as an all-ones limit
  always_comb begin
    lim = '0;
    for (int b = 0; b < PRE_W; b++) begin
      if (b < DIV_STEP * int'(div_i)) lim[b] = 1'b1;
    end
  end

  assign pre_hit = (pre_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (src_tick)  pre_q <= pre_hit ? '0 : pre_q + 1'b1;
  end

  assign tick_o = src_tick && pre_hit;
endmodule

// File: rtl/pwm_engine.sv
module pwm_engine
  import pwm_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  parameter int unsigned DW  = DATA_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  mode_e          mode_i,
  input  logic           restart_i,
  input  logic           tick_i,
  input  logic [DW-1:0]  pend_i [NCH],
  output logic [NCH-1:0] pwm_o
);
  localparam logic [DW-1:0] CNT_TOP = '1;

  logic          single, run, last, load;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] act [NCH];

  assign single = (mode_i == MODE_VARRES);
  assign run    = single || (mode_i == MODE_TWIN16);
  // last channel doubles as period in single mode
  assign last   = single ? (cnt_q == act[NCH-1]) : (cnt_q == CNT_TOP);
  assign load   = restart_i || !run || (tick_i && last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || !run)   cnt_q <= '0;
    else if (tick_i)              cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_out
    logic [DW-1:0] act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   act_q <= '0;
      else if (load) act_q <= pend_i[ch];
    end

    assign act[ch]   = act_q;
    assign pwm_o[ch] = run && (!single || (ch == 0)) && (cnt_q < act_q);
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
#(
  parameter int unsigned NCH      = NUM_CH,
  parameter int unsigned DW       = DATA_W,
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned DIV_STEP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  input  logic              slow_tick_i,
  input  logic              alt_tick_i,
  input  logic              ext_clk_i,
  output logic [NCH-1:0]    pwm_o
);
  ctrl_t            ctrl;
  mode_e            mode_w;
  logic [DIV_W-1:0] div_w;
  src_e             src_w;
  logic             restart;
  logic             tick;
  logic [DW-1:0]    pend [NCH];

  assign mode_w = ctrl.mode;
  assign div_w  = ctrl.div;
  assign src_w  = ctrl.src;

  pwm_regs #(.NCH(NCH), .DW(DW), .AW(AW)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .ctrl_o    (ctrl),
    .restart_o (restart),
    .pend_o    (pend)
  );

  pwm_tick_gen #(.DW_DIV(DIV_W), .DIV_STEP(DIV_STEP), .SYNC_STAGES(2)) i_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_w),
    .div_i       (div_w),
    .restart_i   (restart),
    .slow_tick_i (slow_tick_i),
    .alt_tick_i  (alt_tick_i),
    .ext_clk_i   (ext_clk_i),
    .tick_o      (tick)
  );

  pwm_engine #(.NCH(NCH), .DW(DW)) i_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_w),
    .restart_i (restart),
    .tick_i    (tick),
    .pend_i    (pend),
    .pwm_o     (pwm_o)
  );
endmodule

// File: rtl/pwm_core_chk.sv
module pwm_core_chk
  import pwm_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  parameter int unsigned DW  = DATA_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input mode_e            mode_i,
  input logic [DIV_W-1:0] div_i,
  input logic             restart_i,
  input logic             tick_i,
  input logic [DW-1:0]    pend0_i,
  input logic [NCH-1:0]   pwm_i
);
  logic running;
  assign running = (mode_i == MODE_VARRES) || (mode_i == MODE_TWIN16);

  // R5
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> (pwm_i == '0));

  // R3
  single_out1_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_VARRES) |-> !pwm_i[NCH-1]);

  // R11
  restart_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pwm_i[0] == (running && (pend0_i != '0))));

  // R6
  prescale_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (div_i != '0) && !restart_i) |=> !tick_i);

  // R10
  hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !tick_i && !restart_i) |=> $stable(pwm_i));
endmodule

bind pwm_core pwm_core_chk #(.NCH(NCH), .DW(DW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_w),
  .div_i     (div_w),
  .restart_i (restart),
  .tick_i    (tick),
  .pend0_i   (pend[0]),
  .pwm_i     (pwm_o)
);

// File: tb/test_pwm_core.sv
module test_pwm_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic       slow_tick_i = 1'b0;
  logic       alt_tick_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic [1:0] pwm_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pwm_core i_pwm_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .slow_tick_i (slow_tick_i),
    .alt_tick_i  (alt_tick_i),
    .ext_clk_i   (ext_clk_i),
    .pwm_o       (pwm_o)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  div;
    logic [15:0] d0;
    logic [15:0] d1;
    logic [19:0] win;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 2'd0, 16'd3,      16'd9,      20'd40},
    '{3'd1, 2'd1, 16'd2,      16'd4,      20'd60},
    '{3'd1, 2'd2, 16'd1,      16'd1,      20'd128},
    '{3'd1, 2'd3, 16'd2,      16'd3,      20'd512},
    '{3'd1, 2'd0, 16'd1,      16'd0,      20'd20},
    '{3'd3, 2'd0, 16'd100,    16'd0,      20'd300},
    '{3'd3, 2'd1, 16'd5,      16'hFFFF,   20'd200},
    '{3'd3, 2'd0, 16'hFFFF,   16'd1,      20'd65540}
  };

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we_i = 1'b1;
    reg_addr_i = a;
    reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic setup(input logic [7:0] ctrl, input logic [15:0] d0, input logic [15:0] d1);
    wr(3'd0, 8'h00);
    wr(3'd1, d0[7:0]);
    wr(3'd2, d0[15:8]);
    wr(3'd3, d1[7:0]);
    wr(3'd4, d1[15:8]);
    wr(3'd0, ctrl);
  endtask

  task automatic run_cnt(input int n, output int h0, output int h1);
    h0 = 0;
    h1 = 0;
    repeat (n) begin
      h0 += int'(pwm_o[0]);
      h1 += int'(pwm_o[1]);
      @(negedge clk_i);
    end
  endtask

  task automatic pulse_slow(input int n);
    repeat (n) begin
      slow_tick_i = 1'b1;
      @(negedge clk_i);
      slow_tick_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  task automatic pulse_alt(input int n);
    repeat (n) begin
      alt_tick_i = 1'b1;
      @(negedge clk_i);
      alt_tick_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  task automatic ext_edge(input int n);
    repeat (n) begin
      ext_clk_i = 1'b1;
      repeat (4) @(negedge clk_i);
      ext_clk_i = 1'b0;
      repeat (4) @(negedge clk_i);
    end
  endtask

  function automatic int exp_high(input int mode, input int div, input int d0,
                                  input int d1, input int win, input int ch);
    int h;
    h = 0;
    for (int i = 0; i < win; i++) begin
      int t;
      int c;
      bit o;
      t = i >> (2 * div);
      o = 1'b0;
      if (mode == 1) begin
        c = t % (d1 + 1);
        o = (ch == 0) && (c < d0);
      end else if (mode == 3) begin
        c = t % 65536;
        o = (c < ((ch == 0) ? d0 : d1));
      end
      h += int'(o);
    end
    return h;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int h0, h1;

    // R1 reset state
    repeat (3) @(negedge clk_i);
    check("R1 outputs in reset", int'(pwm_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_cnt(10, h0, h1);
    check("R1 output0 after reset", h0, 0);
    check("R1 output1 after reset", h1, 0);

    // R3 R4 R6 R2 vector table
    for (int v = 0; v < NVEC; v++) begin
      setup({1'b0, VECS[v].mode, VECS[v].div, 2'b00}, VECS[v].d0, VECS[v].d1);
      run_cnt(int'(VECS[v].win), h0, h1);
      check($sformatf("R3/R4/R6 vec%0d out0", v), h0,
            exp_high(int'(VECS[v].mode), int'(VECS[v].div), int'(VECS[v].d0),
                     int'(VECS[v].d1), int'(VECS[v].win), 0));
      check($sformatf("R3/R4/R6 vec%0d out1", v), h1,
            exp_high(int'(VECS[v].mode), int'(VECS[v].div), int'(VECS[v].d0),
                     int'(VECS[v].d1), int'(VECS[v].win), 1));
    end

    // R5 unsupported modes
    for (int m = 2; m < 8; m++) begin
      if (m == 3) continue;
      setup({1'b0, 3'(m), 2'b00, 2'b00}, 16'h0100, 16'h0200);
      run_cnt(50, h0, h1);
      check($sformatf("R5 mode%0d outputs", m), h0 + h1, 0);
    end

    // R10 commit at period end
    setup(8'h10, 16'd3, 16'd9);
    run_cnt(5, h0, h1);
    check("R3 first part of period", h0, 3);
    wr(3'd1, 8'd10);
    wr(3'd2, 8'd0);
    run_cnt(3, h0, h1);
    check("R10 old duty till period end", h0, 0);
    run_cnt(10, h0, h1);
    check("R10 new duty next period", h0, 10);

    // R9 low byte alone has no effect
    wr(3'd1, 8'd2);
    run_cnt(9, h0, h1);
    check("R9 rest of period", h0, 9);
    run_cnt(10, h0, h1);
    check("R9 full period after low byte", h0, 10);
    wr(3'd2, 8'd0);
    run_cnt(9, h0, h1);
    check("R10 old duty after high byte", h0, 9);
    run_cnt(10, h0, h1);
    check("R10 committed duty", h0, 2);

    // R11 restart; R2 reserved bit ignored
    setup(8'h10, 16'd3, 16'd9);
    run_cnt(6, h0, h1);
    wr(3'd0, 8'h90);
    check("R11 output high right after restart", int'(pwm_o[0]), 1);
    run_cnt(3, h0, h1);
    check("R11 high phase after restart", h0, 3);
    run_cnt(7, h0, h1);
    check("R2 reserved bit, low phase", h0 + h1, 0);

    // R12 high byte on the wrapping tick
    setup(8'h10, 16'd3, 16'd9);
    run_cnt(8, h0, h1);
    wr(3'd1, 8'd7);
    wr(3'd2, 8'd0);
    run_cnt(10, h0, h1);
    check("R12 period after collision keeps old", h0, 3);
    run_cnt(10, h0, h1);
    check("R12 following period uses new", h0, 7);

    // R7 source select
    setup(8'h11, 16'd5, 16'd9);
    pulse_alt(5);
    check("R7 alt ignored on slow source", int'(pwm_o[0]), 1);
    pulse_slow(5);
    check("R7 slow source advances", int'(pwm_o[0]), 0);
    setup(8'h13, 16'd5, 16'd9);
    pulse_slow(5);
    check("R7 slow ignored on alt source", int'(pwm_o[0]), 1);
    pulse_alt(5);
    check("R7 alt source advances", int'(pwm_o[0]), 0);

    // R8 external clock
    setup(8'h12, 16'd5, 16'd9);
    ext_clk_i = 1'b1;
    repeat (20) @(negedge clk_i);
    ext_clk_i = 1'b0;
    repeat (4) @(negedge clk_i);
    ext_edge(3);
    check("R8 four edges, held level once", int'(pwm_o[0]), 1);
    ext_edge(1);
    check("R8 fifth edge", int'(pwm_o[0]), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule